// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder Core

This block recovers the information bits of a rate 1/6 convolutional code with constraint length 7. On each cycle with `in_valid` high it takes one 6-bit received symbol. Each symbol bit is a hard 0/1 decision. For every branch of the 64-state trellis, the block forms the Hamming distance between that symbol and the codeword the encoder would have sent on the branch. All 64 add-compare-select units then update their path metrics together, and each records one survivor bit.

The survivor bits of the most recent 42 symbols are kept in a shift buffer. After each accepted symbol, the decoder starts at the state with the lowest path metric and walks back through that buffer. The oldest input bit on the surviving path is then issued on `out_bit`, qualified by `out_valid`. This gives one decoded bit per received symbol at a fixed delay of 42 symbols. Path metrics are 8 bits wide and are kept bounded by a common subtraction, so streams of any length can be decoded.

The encoder state is its six most recent input bits, with the newest bit at bit 5. Any transmitter that follows the generator convention in R1 and starts from the all-zero state can feed this core directly.

Top module: `viterbi_hd_core`

## Requirements
- R1: Codeword convention. For the branch whose current input bit is u, from an encoder state whose bits are p[5] (newest) down to p[0] (oldest), the 7-bit tap vector is {u, p[5:0]}. Symbol bit j (bit 0 first) is the parity of that vector ANDed with the j-th generator: 1111101, 1111001, 1101001, 1011011, 1010111, 1001111 (octal 175, 171, 151, 133, 127, 117). The next state is {u, p[5:1]}. An error-free stream of this kind, starting from state 0, decodes to the transmitted bits.
- R2: Branch metrics are Hamming distances from 0 to 6. Received symbols with a single flipped bit, scattered sparsely through the stream, are corrected.
- R3: A symbol with all six bits inverted, isolated in an otherwise clean stretch, is corrected.
- R4: `out_valid` pulses for one cycle, one clock after the edge that accepts symbol N, but only when N >= 43 counted since reset. With it, `out_bit` carries the input bit of symbol N-42. No output appears for the first 42 symbols.
- R5: Path metrics never wrap. Whenever the smallest metric exceeds 128, 128 is subtracted from every updated metric, so the minimum stays at or below 134. Streams of thousands of noisy symbols decode correctly.
- R6: A cycle with `in_valid` low leaves all path metrics and survivor history unchanged and produces no `out_valid`.
- R7: A synchronous active-low reset clears `out_valid`, gives state 0 a metric of 0 and every other state a metric of 64, and restarts the symbol count. Decoding then resumes correctly from encoder state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Received symbol present this cycle |
| in_sym | input | 6 | Received hard-decision symbol, bit j is code output j |
| out_valid | output | 1 | Decoded bit present this cycle |
| out_bit | output | 1 | Decoded information bit |

## Verification
The bench builds the core with its default 42-symbol traceback, 8-bit path metrics and a normalisation threshold of 128. The long noisy phase injects an error into about a quarter of the symbols, which pushes the smallest metric past the threshold several times. Every decoded bit is compared against the transmitted bit across those subtractions. Random idle gaps, a whole-symbol inversion every fifty symbols and a reset in the middle of a stream exercise the hold, correction and restart cases. All of these run at the exact output timing defined in R4.

// File: rtl/vit_pkg.sv
// Shared constants, types and codeword helpers for the hard-decision decoder.
// Assumes a fixed rate 1/6, constraint length 7 code; state = last six input
// bits with the newest bit in the most significant position.
package vit_pkg;
    localparam int CONSTR = 7;
    localparam int ST_W   = CONSTR - 1;
    localparam int N_ST   = 1 << ST_W;
    localparam int SYM_W  = 6;
    localparam int BM_W   = 3;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [ST_W-1:0]  state_t;
    typedef logic [BM_W-1:0]  bm_t;

    // Codeword on the branch entering state nxt whose dropped (oldest) bit is drop.
    function automatic sym_t expect_sym(input state_t nxt, input logic drop);
        logic [CONSTR-1:0] taps;
        sym_t c;
        taps = {nxt, drop};
        c[0] = ^(taps & 7'o175);
        c[1] = ^(taps & 7'o171);
        c[2] = ^(taps & 7'o151);
        c[3] = ^(taps & 7'o133);
        c[4] = ^(taps & 7'o127);
        c[5] = ^(taps & 7'o117);
        return c;
    endfunction

    // Number of differing bits between two symbols.
    function automatic bm_t hamming(input sym_t a, input sym_t b);
        sym_t d;
        bm_t acc;
        d = a ^ b;
        acc = '0;
        for (int i = 0; i < SYM_W; i++) begin
            acc = acc + bm_t'(d[i]);
        end
        return acc;
    endfunction
endpackage

// File: rtl/vit_bmu.sv
// Branch metric unit: Hamming distance of the received symbol to the expected
// codeword of each of the two branches entering every state. Purely combinational.
module vit_bmu
    import vit_pkg::*;
(
    input  sym_t                              rx_sym,
    output logic [N_ST-1:0][1:0][BM_W-1:0]    bm
);
    for (genvar n = 0; n < N_ST; n++) begin : g_state
        for (genvar b = 0; b < 2; b++) begin : g_branch
            // distance of this branch's codeword to the received symbol
            assign bm[n][b] = hamming(rx_sym, expect_sym(state_t'(n), 1'(b)));
        end
    end
endmodule

// File: rtl/vit_minsel.sv
// Finds the smallest path metric and the lowest-numbered state holding it.
// Assumes metrics are unsigned; ties resolve to the lower state index.
module vit_minsel
    import vit_pkg::*;
#(
    parameter int PM_W = 8
) (
    input  logic [N_ST-1:0][PM_W-1:0] pm,
    output logic [PM_W-1:0]           min_val,
    output state_t                    min_idx
);
    // linear scan keeping the first strict minimum
    always_comb begin
        min_val = pm[0];
        min_idx = '0;
        for (int i = 1; i < N_ST; i++) begin
            if (pm[i] < min_val) begin
                min_val = pm[i];
                min_idx = state_t'(i);
            end
        end
    end
endmodule

// File: rtl/vit_acs.sv
// Add-compare-select array for all states, with path metric registers and
// threshold normalisation. Assumes bm and pm_min are valid in the same cycle
// as in_valid; survivor bits are produced combinationally for the buffer.
module vit_acs
    import vit_pkg::*;
#(
    parameter int PM_W    = 8,
    parameter int INIT_PM = 64,
    parameter int NORM_TH = 128
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [N_ST-1:0][1:0][BM_W-1:0] bm,
    input  logic [PM_W-1:0]                pm_min,
    output logic [N_ST-1:0][PM_W-1:0]      pm,
    output logic [N_ST-1:0]                dec_next
);
    localparam int SUM_W = PM_W + 1;

    logic                      norm;
    logic [N_ST-1:0][PM_W-1:0] pm_next;

    assign norm = pm_min > PM_W'(NORM_TH);

    for (genvar n = 0; n < N_ST; n++) begin : g_acs
        localparam int P0 = (2 * n) % N_ST;
        localparam int P1 = P0 + 1;
        logic [SUM_W-1:0] c0, c1, win;
        logic             sel;

        // add both candidates, keep the smaller (ties keep dropped bit 0), normalise
        always_comb begin
            c0  = SUM_W'(pm[P0]) + SUM_W'(bm[n][0]);
            c1  = SUM_W'(pm[P1]) + SUM_W'(bm[n][1]);
            sel = c1 < c0;
            win = sel ? c1 : c0;
            if (norm) begin
                win = win - SUM_W'(NORM_TH);
            end
        end

        assign pm_next[n]  = win[PM_W-1:0];
        assign dec_next[n] = sel;

        // R5: the surviving sum must fit the metric width after normalisation
        assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (win[PM_W] == 1'b0));
    end

    // path metric registers: seeded at reset, updated only on accepted symbols
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ST; i++) begin
                pm[i] <= (i == 0) ? '0 : PM_W'(INIT_PM);
            end
        end else if (in_valid) begin
            pm <= pm_next;
        end
    end

    // R5: normalisation keeps the smallest metric within one branch of the threshold
    assert_min_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_min <= PM_W'(NORM_TH + SYM_W));

    // R6: idle cycles leave every metric untouched
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(pm));

    // R7: leaving reset, state 0 starts at zero and its neighbour at the seed value
    assert_reset_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pm[0] == '0 && pm[1] == PM_W'(INIT_PM)));
endmodule

// File: rtl/vit_trace.sv
// Survivor history and traceback. Keeps the decision vectors of the last DEPTH
// symbols in a shift buffer and, after every accepted symbol, walks back from
// the start state to emit the oldest bit. History storage carries no reset;
// the symbol counter alone decides when output is valid.
module vit_trace
    import vit_pkg::*;
#(
    parameter int DEPTH = 42
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [N_ST-1:0] dec_new,
    input  state_t          start,
    output logic            out_valid,
    output logic            out_bit
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [N_ST-1:0]  hist [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             fire;
    logic             trace_bit;

    // shift the newest decision vector into the history
    always_ff @(posedge clk) begin
        if (in_valid) begin
            hist[0] <= dec_new;
            for (int i = 1; i < DEPTH; i++) begin
                hist[i] <= hist[i-1];
            end
        end
    end

    // count accepted symbols up to DEPTH and flag when a trace is due
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= in_valid && (cnt == CNT_W'(DEPTH));
            if (in_valid && cnt != CNT_W'(DEPTH)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // walk predecessors through the whole history; the final state's MSB is the bit
    always_comb begin
        state_t s;
        s = start;
        for (int i = 0; i < DEPTH; i++) begin
            s = {s[ST_W-2:0], hist[i][s]};
        end
        trace_bit = s[ST_W-1];
    end

    // register the decoded bit and its qualifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= fire;
            out_bit   <= fire ? trace_bit : 1'b0;
        end
    end

    // R4: each output follows an accepted symbol two edges earlier
    assert_valid_after_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R4: an output only appears once the history is full
    assert_history_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(cnt, 2) == CNT_W'(DEPTH)));
endmodule

// File: rtl/viterbi_hd_core.sv
// Top of the hard-decision decoder: branch metrics, add-compare-select with
// normalisation, minimum search and traceback. Assumes one symbol per cycle
// at most, qualified by in_valid, and an encoder that starts in state 0.
module viterbi_hd_core
    import vit_pkg::*;
#(
    parameter int TB_DEPTH = 42,
    parameter int PM_W     = 8,
    parameter int INIT_PM  = 64,
    parameter int NORM_TH  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_sym,
    output logic             out_valid,
    output logic             out_bit
);
    logic [N_ST-1:0][1:0][BM_W-1:0] bm;
    logic [N_ST-1:0][PM_W-1:0]      pm;
    logic [N_ST-1:0]                dec_next;
    logic [PM_W-1:0]                pm_min;
    state_t                         best;

    vit_bmu u_bmu (
        .rx_sym (in_sym),
        .bm     (bm)
    );

    vit_minsel #(.PM_W(PM_W)) u_min (
        .pm      (pm),
        .min_val (pm_min),
        .min_idx (best)
    );

    vit_acs #(
        .PM_W    (PM_W),
        .INIT_PM (INIT_PM),
        .NORM_TH (NORM_TH)
    ) u_acs (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .bm       (bm),
        .pm_min   (pm_min),
        .pm       (pm),
        .dec_next (dec_next)
    );

    vit_trace #(.DEPTH(TB_DEPTH)) u_trace (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .dec_new   (dec_next),
        .start     (best),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );
endmodule

// File: tb/viterbi_hd_core_test.sv
// Self-checking bench: a bench-side encoder feeds the core, and a reference
// queue predicts each decoded bit and the cycle in which it must appear.
module viterbi_hd_core_test;
    localparam int D = 42;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] in_sym = '0;
    logic       out_valid;
    logic       out_bit;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string phase = "R1";

    logic [5:0] enc = '0;
    logic       src [0:8191];
    int         wr = 0;
    int         rx = 0;
    logic       exp_v_n = 1'b0, exp_v = 1'b0;
    logic       exp_b_n = 1'b0, exp_b = 1'b0;

    always #10 clk = ~clk;

    viterbi_hd_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sym    (in_sym),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    function automatic logic [5:0] code_sym(input logic [5:0] st, input logic u);
        logic [6:0] v;
        logic [5:0] c;
        v = {u, st};
        c[0] = ^(v & 7'b1111101);
        c[1] = ^(v & 7'b1111001);
        c[2] = ^(v & 7'b1101001);
        c[3] = ^(v & 7'b1011011);
        c[4] = ^(v & 7'b1010111);
        c[5] = ^(v & 7'b1001111);
        return c;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // prediction of timing and value, advanced on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            rx      <= 0;
            exp_v_n <= 1'b0;
            exp_v   <= 1'b0;
        end else begin
            exp_v <= exp_v_n;
            exp_b <= exp_b_n;
            if (in_valid) begin
                rx      <= rx + 1;
                exp_v_n <= (rx + 1) >= D + 1;
                exp_b_n <= (rx >= D) ? src[rx - D] : 1'b0;
            end else begin
                exp_v_n <= 1'b0;
            end
        end
    end

    // compare outputs half a cycle after each edge (R4 timing, R6 silence)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (out_valid !== exp_v) begin
                errors++;
                $display("FAIL R4/R6 out_valid actual %b expected %b", out_valid, exp_v);
            end else if (exp_v) begin
                checks++;
                if (out_bit !== exp_b) begin
                    errors++;
                    $display("FAIL %s out_bit actual %b expected %b", phase, out_bit, exp_b);
                end
            end
        end
    end

    task automatic send(input logic u, input logic [5:0] emask);
        @(negedge clk);
        in_sym   = code_sym(enc, u) ^ emask;
        in_valid = 1'b1;
        enc      = {u, enc[5:1]};
        src[wr]  = u;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sym   = 6'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        enc      = '0;
        wr       = 0;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R7 out_valid in reset actual %b expected 0", out_valid);
        end
        rst_n = 1'b1;
    endtask

    function automatic logic [5:0] one_flip();
        return 6'(1) << ($urandom % 6);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual hung expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd1207));
        do_reset();
        // R1 with R6: clean random bits, random idle gaps in between
        phase = "R1";
        for (int i = 0; i < 100; i++) begin
            send(1'($urandom), 6'd0);
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        // R1: long constant runs
        for (int i = 0; i < 60; i++) send(1'b0, 6'd0);
        for (int i = 0; i < 60; i++) send(1'b1, 6'd0);
        // R2: sparse single-bit errors
        phase = "R2";
        for (int i = 0; i < 400; i++)
            send(1'($urandom), ($urandom % 8 == 0) ? one_flip() : 6'd0);
        // R3: fully inverted symbol every fiftieth
        phase = "R3";
        for (int i = 0; i < 300; i++)
            send(1'($urandom), (i % 50 == 25) ? 6'h3F : 6'd0);
        // R7: reset mid-stream, then restart from state 0
        phase = "R7";
        for (int i = 0; i < 20; i++) send(1'($urandom), 6'd0);
        do_reset();
        for (int i = 0; i < 120; i++) send(1'($urandom), 6'd0);
        // R5: long noisy stream crossing the normalisation threshold repeatedly
        phase = "R5";
        for (int i = 0; i < 3000; i++)
            send(1'($urandom), ($urandom % 4 == 0) ? one_flip() : 6'd0);
        idle(5);
        summary();
    end
endmodule